// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit instruction address of a small 8-bit controller core. The address is split into a low byte, which the data path may read and overwrite like any other register, and upper bits that the data path never touches directly. Those upper bits come from a separate 5-bit page register. Software writes that register before it changes the low byte or before it executes a jump.

Each clock the counter takes one of four new values, or keeps its value. It can step to the next address, take a byte from the ALU into its low half, take the immediate field of a jump or call, or take an address popped from the return stack. A low-byte write takes every upper bit from the page register. A jump takes only the top two page bits, because its immediate already covers the lower eleven address bits. Instruction decode, the return stack storage and the memories lie outside the block.

Top module: `prog_counter_unit`

## Requirements
- R1: While `rst_n_i` is low, `pc_o` is 0x0000 and `page_rdata_o` is 0x00, whatever the other inputs do.
- R2: With only `inc_en_i` high, `pc_o` becomes the old value plus one at the next rising edge, and 0x1FFF steps to 0x0000.
- R3: A low-byte write (`lo_wr_i`) loads `pc_o[7:0]` with `lo_wdata_i` and `pc_o[12:8]` with page bits 4:0. The upper bits come only from the page register, so adding an offset to the low byte never carries into bit 8.
- R4: A jump (`jmp_i`) loads `pc_o[10:0]` with `jmp_imm_i` and `pc_o[12:11]` with page bits 4:3.
- R5: A return load (`ret_ld_i`) loads `pc_o` with `ret_pc_i`.
- R6: When several load requests are high in one cycle, the winner is, from highest: return load, jump, low-byte write, increment.
- R7: A page write (`page_wr_i`) stores `page_wdata_i` at the next edge. `page_rdata_o` shows it in bits 4:0, with bits 7:5 reading zero. A PC load in the same cycle uses the page value held before that edge.
- R8: `pc_lo_o` always equals `pc_o[7:0]`.
- R9: With no request high, `pc_o` holds its value.
- R10: Return, jump, low-byte and increment loads never change the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| inc_en_i | input | 1 | Step to the next address |
| lo_wr_i | input | 1 | Data-path write of the low byte |
| lo_wdata_i | input | 8 | ALU result for the low byte |
| jmp_i | input | 1 | Jump or call request |
| jmp_imm_i | input | 11 | Immediate address field of the jump |
| page_wr_i | input | 1 | Write strobe of the page register |
| page_wdata_i | input | 5 | New page value |
| ret_ld_i | input | 1 | Load from the return stack |
| ret_pc_i | input | 13 | Address popped from the stack |
| pc_o | output | 13 | Current program counter |
| pc_lo_o | output | 8 | Readable low byte of the counter |
| page_rdata_o | output | 8 | Page register read value, upper bits zero |

## Verification
The assertions assume that every input is a defined value at each rising edge while reset is released. They also assume that reset is released away from an edge, so that each property's previous cycle is a cycle in which the block was running. Apart from that they allow any mix of requests in any cycle. The bench drives all inputs only on falling edges and gives every port a defined value before reset is released. It deliberately raises several requests together, so that the priority order and the same-cycle page write are both exercised under those assumptions.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int unsigned PC_W   = 13;
  localparam int unsigned LO_W   = 8;
  localparam int unsigned IMM_W  = 11;
  localparam int unsigned PAGE_W = PC_W - LO_W;
  localparam int unsigned JHI_W  = PC_W - IMM_W;
  localparam int unsigned RD_W   = 8;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LO   = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_RET  = 3'd4
  } pc_src_e;

  // next sequential address, wraps at the top of the space
  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc);
    return PC_W'(pc + PC_W'(1));
  endfunction

  // low byte from the data path, all upper bits from the page register
  function automatic logic [PC_W-1:0] pc_from_low(input logic [PAGE_W-1:0] page,
                                                  input logic [LO_W-1:0]   low);
    return {page, low};
  endfunction

  // immediate field below, top page bits above
  function automatic logic [PC_W-1:0] pc_from_jump(input logic [PAGE_W-1:0] page,
                                                   input logic [IMM_W-1:0]  imm);
    return {page[PAGE_W-1 -: JHI_W], imm};
  endfunction

endpackage

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int unsigned PAGE_W = pcu_pkg::PAGE_W,
  parameter int unsigned RD_W   = pcu_pkg::RD_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [RD_W-1:0]   rdata_o
);

  localparam int unsigned PAD_W = RD_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      page_q <= '0;
    end else if (wr_i) begin
      page_q <= wdata_i;
    end
  end

  assign page_o  = page_q;
  assign rdata_o = {{PAD_W{1'b0}}, page_q};

endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W_P   = pcu_pkg::PC_W,
  parameter int unsigned LO_W_P   = pcu_pkg::LO_W,
  parameter int unsigned IMM_W_P  = pcu_pkg::IMM_W,
  parameter int unsigned PAGE_W_P = pcu_pkg::PAGE_W
) (
  input  logic [PC_W_P-1:0]   pc_i,
  input  logic [PAGE_W_P-1:0] page_i,
  input  logic                inc_en_i,
  input  logic                lo_wr_i,
  input  logic [LO_W_P-1:0]   lo_wdata_i,
  input  logic                jmp_i,
  input  logic [IMM_W_P-1:0]  jmp_imm_i,
  input  logic                ret_ld_i,
  input  logic [PC_W_P-1:0]   ret_pc_i,
  output pc_src_e             src_o,
  output logic                load_o,
  output logic [PC_W_P-1:0]   pc_next_o,
  output logic                ev_ret_o,
  output logic                ev_jmp_o,
  output logic                ev_lo_o,
  output logic                ev_inc_o
);

  pc_src_e src;

  // fixed priority: stack return, jump, low-byte write, step
  always_comb begin
    if (ret_ld_i)      src = SRC_RET;
    else if (jmp_i)    src = SRC_JMP;
    else if (lo_wr_i)  src = SRC_LO;
    else if (inc_en_i) src = SRC_INC;
    else               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_RET:  pc_next_o = ret_pc_i;
      SRC_JMP:  pc_next_o = pc_from_jump(page_i, jmp_imm_i);
      SRC_LO:   pc_next_o = pc_from_low(page_i, lo_wdata_i);
      SRC_INC:  pc_next_o = pc_step(pc_i);
      default:  pc_next_o = pc_i;
    endcase
  end

  assign src_o    = src;
  assign load_o   = (src != SRC_HOLD);
  assign ev_ret_o = (src == SRC_RET);
  assign ev_jmp_o = (src == SRC_JMP);
  assign ev_lo_o  = (src == SRC_LO);
  assign ev_inc_o = (src == SRC_INC);

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int unsigned PC_W = pcu_pkg::PC_W
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] d_i,
  output logic [PC_W-1:0] q_o
);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pc_q <= '0;
    end else if (load_i) begin
      pc_q <= d_i;
    end
  end

  assign q_o = pc_q;

endmodule

// File: rtl/prog_counter_unit.sv
module prog_counter_unit
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W_P   = pcu_pkg::PC_W,
  parameter int unsigned LO_W_P   = pcu_pkg::LO_W,
  parameter int unsigned IMM_W_P  = pcu_pkg::IMM_W,
  parameter int unsigned PAGE_W_P = pcu_pkg::PAGE_W,
  parameter int unsigned RD_W_P   = pcu_pkg::RD_W
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                inc_en_i,
  input  logic                lo_wr_i,
  input  logic [LO_W_P-1:0]   lo_wdata_i,
  input  logic                jmp_i,
  input  logic [IMM_W_P-1:0]  jmp_imm_i,
  input  logic                page_wr_i,
  input  logic [PAGE_W_P-1:0] page_wdata_i,
  input  logic                ret_ld_i,
  input  logic [PC_W_P-1:0]   ret_pc_i,
  output logic [PC_W_P-1:0]   pc_o,
  output logic [LO_W_P-1:0]   pc_lo_o,
  output logic [RD_W_P-1:0]   page_rdata_o
);

  logic [PAGE_W_P-1:0] page_q;
  logic [PC_W_P-1:0]   pc_q;
  logic [PC_W_P-1:0]   pc_next;
  logic                pc_load;
  pc_src_e             pc_src;
  logic                ev_ret, ev_jmp, ev_lo, ev_inc;

  pcu_page_latch #(.PAGE_W(PAGE_W_P), .RD_W(RD_W_P)) u_page (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .wr_i    (page_wr_i),
    .wdata_i (page_wdata_i),
    .page_o  (page_q),
    .rdata_o (page_rdata_o)
  );

  pcu_next_sel #(
    .PC_W_P(PC_W_P), .LO_W_P(LO_W_P), .IMM_W_P(IMM_W_P), .PAGE_W_P(PAGE_W_P)
  ) u_sel (
    .pc_i       (pc_q),
    .page_i     (page_q),
    .inc_en_i   (inc_en_i),
    .lo_wr_i    (lo_wr_i),
    .lo_wdata_i (lo_wdata_i),
    .jmp_i      (jmp_i),
    .jmp_imm_i  (jmp_imm_i),
    .ret_ld_i   (ret_ld_i),
    .ret_pc_i   (ret_pc_i),
    .src_o      (pc_src),
    .load_o     (pc_load),
    .pc_next_o  (pc_next),
    .ev_ret_o   (ev_ret),
    .ev_jmp_o   (ev_jmp),
    .ev_lo_o    (ev_lo),
    .ev_inc_o   (ev_inc)
  );

  pcu_pc_reg #(.PC_W(PC_W_P)) u_pc (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .load_i  (pc_load),
    .d_i     (pc_next),
    .q_o     (pc_q)
  );

  assign pc_o    = pc_q;
  assign pc_lo_o = pc_q[LO_W_P-1:0];

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int unsigned PC_W_P   = pcu_pkg::PC_W,
  parameter int unsigned LO_W_P   = pcu_pkg::LO_W,
  parameter int unsigned IMM_W_P  = pcu_pkg::IMM_W,
  parameter int unsigned PAGE_W_P = pcu_pkg::PAGE_W,
  parameter int unsigned RD_W_P   = pcu_pkg::RD_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inc_en,
  input logic                lo_wr,
  input logic [LO_W_P-1:0]   lo_wdata,
  input logic                jmp,
  input logic [IMM_W_P-1:0]  jmp_imm,
  input logic                page_wr,
  input logic [PAGE_W_P-1:0] page_wdata,
  input logic                ret_ld,
  input logic [PC_W_P-1:0]   ret_pc,
  input logic [PC_W_P-1:0]   pc,
  input logic [RD_W_P-1:0]   page_rd,
  input logic                ev_ret,
  input logic                ev_jmp,
  input logic                ev_lo,
  input logic                ev_inc
);

  localparam int unsigned JHI_W = PC_W_P - IMM_W_P;
  localparam int unsigned PAD_W = RD_W_P - PAGE_W_P;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_val_R1: assert (pc == '0 && page_rd == '0)
        else $error("pc or page not cleared in reset");
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !lo_wr && !jmp && !ret_ld) |=> pc == PC_W_P'($past(pc) + PC_W_P'(1)));

  assert_low_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !jmp && !ret_ld) |=>
      pc == {$past(page_rd[PAGE_W_P-1:0]), $past(lo_wdata)});

  assert_jump_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp && !ret_ld) |=>
      pc == {$past(page_rd[PAGE_W_P-1 -: JHI_W]), $past(jmp_imm)});

  assert_ret_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ld |=> pc == $past(ret_pc));

  assert_one_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ret, ev_jmp, ev_lo, ev_inc}));

  assert_ret_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ld |-> (ev_ret && !ev_jmp && !ev_lo && !ev_inc));

  assert_page_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> page_rd == {{PAD_W{1'b0}}, $past(page_wdata)});

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !lo_wr && !jmp && !ret_ld) |=> $stable(pc));

  assert_page_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !page_wr |=> $stable(page_rd));

endmodule

bind prog_counter_unit pcu_checker #(
  .PC_W_P(PC_W_P), .LO_W_P(LO_W_P), .IMM_W_P(IMM_W_P),
  .PAGE_W_P(PAGE_W_P), .RD_W_P(RD_W_P)
) u_pcu_checker (
  .clk        (clk_i),
  .rst_n      (rst_n_i),
  .inc_en     (inc_en_i),
  .lo_wr      (lo_wr_i),
  .lo_wdata   (lo_wdata_i),
  .jmp        (jmp_i),
  .jmp_imm    (jmp_imm_i),
  .page_wr    (page_wr_i),
  .page_wdata (page_wdata_i),
  .ret_ld     (ret_ld_i),
  .ret_pc     (ret_pc_i),
  .pc         (pc_o),
  .page_rd    (page_rdata_o),
  .ev_ret     (ev_ret),
  .ev_jmp     (ev_jmp),
  .ev_lo      (ev_lo),
  .ev_inc     (ev_inc)
);

// File: tb/test_prog_counter_unit.sv
`timescale 1ns/1ps
module test_prog_counter_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inc_en, lo_wr, jmp, page_wr, ret_ld;
  logic [7:0]  lo_wdata;
  logic [10:0] jmp_imm;
  logic [4:0]  page_wdata;
  logic [12:0] ret_pc;
  logic [12:0] pc;
  logic [7:0]  pc_lo;
  logic [7:0]  page_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prog_counter_unit i_prog_counter_unit (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .inc_en_i     (inc_en),
    .lo_wr_i      (lo_wr),
    .lo_wdata_i   (lo_wdata),
    .jmp_i        (jmp),
    .jmp_imm_i    (jmp_imm),
    .page_wr_i    (page_wr),
    .page_wdata_i (page_wdata),
    .ret_ld_i     (ret_ld),
    .ret_pc_i     (ret_pc),
    .pc_o         (pc),
    .pc_lo_o      (pc_lo),
    .page_rdata_o (page_rd)
  );

  typedef struct packed {
    logic        ret;
    logic [12:0] ret_pc;
    logic        jmp;
    logic [10:0] imm;
    logic        lo;
    logic [7:0]  lo_d;
    logic        pw;
    logic [4:0]  pw_d;
    logic        inc;
    logic [12:0] exp_pc;
    logic [7:0]  exp_page;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b1, 13'h0001, 8'h00}, // R2
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b1, 13'h0002, 8'h00}, // R2
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b1, 5'h1F, 1'b0, 13'h0002, 8'h1F}, // R7 R9
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b1, 8'h34, 1'b0, 5'h00, 1'b0, 13'h1F34, 8'h1F}, // R3
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b1, 13'h1F35, 8'h1F}, // R2
    '{1'b0, 13'h0000, 1'b1, 11'h7AB, 1'b0, 8'h00, 1'b0, 5'h00, 1'b0, 13'h1FAB, 8'h1F}, // R4
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b1, 5'h0A, 1'b0, 13'h1FAB, 8'h0A}, // R7
    '{1'b0, 13'h0000, 1'b1, 11'h123, 1'b1, 8'h55, 1'b0, 5'h00, 1'b1, 13'h0923, 8'h0A}, // R4 R6
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b1, 8'hFF, 1'b0, 5'h00, 1'b1, 13'h0AFF, 8'h0A}, // R3 R6
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b1, 13'h0B00, 8'h0A}, // R2 carry
    '{1'b1, 13'h1FFF, 1'b1, 11'h000, 1'b1, 8'h00, 1'b1, 5'h03, 1'b1, 13'h1FFF, 8'h03}, // R5 R6 R7
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b1, 13'h0000, 8'h03}, // R2 wrap
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b1, 8'h10, 1'b1, 5'h1C, 1'b0, 13'h0310, 8'h1C}, // R7 old page
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b0, 13'h0310, 8'h1C}, // R9
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b1, 8'h05, 1'b0, 5'h00, 1'b0, 13'h1C05, 8'h1C}, // R3
    '{1'b1, 13'h0ABC, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b0, 13'h0ABC, 8'h1C}, // R5 R10
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b1, 8'hEE, 1'b0, 5'h00, 1'b1, 13'h1CEE, 8'h1C}, // R3 R6
    '{1'b0, 13'h0000, 1'b0, 11'h000, 1'b0, 8'h00, 1'b0, 5'h00, 1'b1, 13'h1CEF, 8'h1C}  // R2
  };

  function automatic string pc_req(input vec_t v);
    int n = int'(v.ret) + int'(v.jmp) + int'(v.lo) + int'(v.inc);
    string s;
    if (v.ret)      s = "R5";
    else if (v.jmp) s = "R4";
    else if (v.lo)  s = "R3";
    else if (v.inc) s = "R2";
    else            s = "R9";
    if (n > 1) s = {s, "/R6"};
    return s;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    inc_en = 0; lo_wr = 0; jmp = 0; page_wr = 0; ret_ld = 0;
    lo_wdata = '0; jmp_imm = '0; page_wdata = '0; ret_pc = '0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    inc_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", pc, 13'h0000);
    check("R1", "page in reset", {5'b0, page_rd}, 13'h0000);
    inc_en = 1'b0;
    rst_n  = 1'b1;

    for (int i = 0; i < NV; i++) begin
      inc_en     = VECS[i].inc;
      lo_wr      = VECS[i].lo;
      lo_wdata   = VECS[i].lo_d;
      jmp        = VECS[i].jmp;
      jmp_imm    = VECS[i].imm;
      page_wr    = VECS[i].pw;
      page_wdata = VECS[i].pw_d;
      ret_ld     = VECS[i].ret;
      ret_pc     = VECS[i].ret_pc;
      @(negedge clk);
      check(pc_req(VECS[i]), "pc", pc, VECS[i].exp_pc);
      check("R8", "pc low byte", {5'b0, pc_lo}, {5'b0, VECS[i].exp_pc[7:0]});
      check(VECS[i].pw ? "R7" : "R10", "page readback",
            {5'b0, page_rd}, {5'b0, VECS[i].exp_page});
    end
    idle_inputs();

    // R1: reset mid-run clears asynchronously and holds against requests
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "pc after async reset", pc, 13'h0000);
    check("R1", "page after async reset", {5'b0, page_rd}, 13'h0000);
    inc_en = 1'b1; page_wr = 1'b1; page_wdata = 5'h11;
    @(negedge clk);
    check("R1", "pc held in reset", pc, 13'h0000);
    check("R1", "page held in reset", {5'b0, page_rd}, 13'h0000);
    page_wr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "first step after reset", pc, 13'h0001);

    // R4: jump with page bits 2:0 set takes only bits 4:3
    inc_en = 1'b0; page_wr = 1'b1; page_wdata = 5'h17;
    @(negedge clk);
    page_wr = 1'b0; jmp = 1'b1; jmp_imm = 11'h0FF;
    @(negedge clk);
    check("R4", "jump uses page bits 4:3", pc, 13'h10FF);
    check("R8", "pc low byte after jump", {5'b0, pc_lo}, 13'h00FF);
    jmp = 1'b0;

    // R3: computed offset past 0xFF wraps inside the page
    lo_wr = 1'b1; lo_wdata = 8'(8'hFF + 8'h02);
    @(negedge clk);
    check("R3", "computed jump no carry", pc, 13'h1701);
    lo_wr = 1'b0;
    @(negedge clk);
    check("R9", "hold when idle", pc, 13'h1701);
    check("R10", "page unchanged by loads", {5'b0, page_rd}, 13'h0017);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule